// File: doc/BRIEF.md
# Frame-Table Line Parser and Sequencer

This block walks one channel's 16-bit waveform memory and turns it into a stream of decoded waveform lines for a downstream spline engine. The first eight memory words form a jump table, one start address per frame. When the sequencer is armed and frame starts are enabled, it reads the table entry named by the 3-bit frame select input. It then jumps to that address and parses lines. Each line is a packed header word, a duration word and up to fourteen coefficient words. Coefficient words that the line does not carry are delivered as zero.

Parsing runs ahead of execution. One fully parsed line waits in an output register and is offered to the spline engine through a valid/ready handshake. The offer is held back only when the line must wait for the trigger level: either the line's own trigger flag is set, or the previously started line carried the wait flag. The trigger level is the OR of an external input and a soft input. After a line with the end flag, the parser goes back to the jump table. Dropping the arm input discards the unstarted line and parks the parser. A registered auxiliary output follows the aux flag of the most recently started line.

Top module: `frame_line_seq`

## Requirements
- R1: With arm and start_en high, the parser reads memory word frame_sel and then parses lines from the address that word holds. The first line offered is the one at that address.
- R2: A line's header word is decoded as follows: bit 15 wait, bit 14 clear, bit 13 end, bits 12..11 shift, bit 8 aux, bit 7 silence, bit 6 trigger, bits 5..4 typ and bits 3..0 length. The length counts the words after the header. The first of those words is the duration, and the word after the line's last word is the next header.
- R3: Coefficient word k (0..13) on ln_data[16k+15:16k] is memory word header+2+k when k+2 <= length, and zero otherwise.
- R4: After a line with the end bit is offered, the next line comes from the table entry of the current frame_sel.
- R5: A line with the trigger bit is not offered (ln_valid low) while ext_trig and soft_trig are both low. It is offered as soon as either input is high. Lines without the bit need no trigger.
- R6: After a line with the wait bit is accepted, the next line is not offered until the trigger level is high. That next line is parsed in the meantime, so it is offered in the same cycle the trigger rises.
- R7: While arm is low, no line is offered and, from the second cycle on, no memory read is made. After re-arming, the first line offered is the first line of the selected frame.
- R8: With start_en low, the parser makes no memory read. A table entry of 0 keeps the parser parked, so no line is offered.
- R9: Lines are offered strictly in memory order. An offered line stays unchanged until ln_ready accepts it, however long that takes.
- R10: From the cycle after a line is accepted, aux_out equals that line's aux bit, and it holds until the next acceptance.
- R11: During and right after reset, ln_valid, mem_rd and aux_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Arm level; low aborts parsing |
| start_en | input | 1 | Allows leaving the jump table |
| frame_sel | input | 3 | Selected frame |
| ext_trig | input | 1 | External trigger level |
| soft_trig | input | 1 | Soft trigger level |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 16 | Read data, one cycle after the strobe |
| ln_valid | output | 1 | Line offered |
| ln_ready | input | 1 | Spline engine accepts the line |
| ln_typ | output | 2 | Target spline type |
| ln_shift | output | 2 | Duration exponent |
| ln_trigger | output | 1 | Line waited for trigger |
| ln_wait | output | 1 | Next line waits for trigger |
| ln_end | output | 1 | Last line of the frame |
| ln_clear | output | 1 | Phase clear flag |
| ln_silence | output | 1 | Silence flag |
| ln_aux | output | 1 | Aux flag of the offered line |
| ln_dur | output | 16 | Duration word |
| ln_data | output | 224 | Fourteen coefficient words, word 0 lowest |
| aux_out | output | 1 | Aux level of the line being executed |

## Verification
The hardest state to reach is a fully parsed line that is held back by the wait flag of the line before it. Reaching it takes a frame whose first line is triggered, whose second carries wait and whose third follows. The trigger is kept low and the ready input is kept low while the parser runs ahead. The bench then shows that nothing is offered for many cycles and that the held line appears in the cycle the trigger rises. A disarm is also forced while a line is waiting on the handshake, and a longer random frame is read with random ready stalls to exercise ordering and the zero padding of short lines.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  localparam int WORD_W  = 16;
  localparam int NCOEF   = 14;
  localparam int NSLOT   = NCOEF + 1;
  localparam int DATA_W  = NCOEF * WORD_W;

  typedef struct packed {
    logic       wait_next;
    logic       clr;
    logic       last;
    logic [1:0] shift;
    logic       aux;
    logic       silence;
    logic       trig_req;
    logic [1:0] typ;
    logic [3:0] len;
  } hdr_t;

  typedef struct packed {
    hdr_t              hdr;
    logic [WORD_W-1:0] dur;
    logic [DATA_W-1:0] coef;
  } line_t;

  function automatic hdr_t decode_hdr(input logic [WORD_W-1:0] w);
    hdr_t h;
    h.wait_next = w[15];
    h.clr       = w[14];
    h.last      = w[13];
    h.shift     = w[12:11];
    h.aux       = w[8];
    h.silence   = w[7];
    h.trig_req  = w[6];
    h.typ       = w[5:4];
    h.len       = w[3:0];
    return h;
  endfunction
endpackage

// File: rtl/line_fetch.sv
module line_fetch
  import frame_seq_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              start_en,
  input  logic [2:0]        frame_sel,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              p_valid,
  output line_t             p_line,
  input  logic              p_take
);
  typedef enum logic [2:0] {S_PARK, S_TBL, S_HDR, S_WRD, S_DONE} st_e;

  st_e           state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  hdr_t          hdr_q;
  logic [3:0]    idx_q, idx_d;
  logic          hdr_we, slot_clr, slot_we;
  logic [WORD_W-1:0] slot_q [NSLOT];

  logic [AW-1:0] entry;
  hdr_t          hdr_in;
  assign entry  = mem_rdata[AW-1:0];
  assign hdr_in = decode_hdr(mem_rdata);

  always_comb begin
    state_d  = state_q;
    ptr_d    = ptr_q;
    idx_d    = idx_q;
    mem_rd   = 1'b0;
    mem_addr = ptr_q;
    hdr_we   = 1'b0;
    slot_clr = 1'b0;
    slot_we  = 1'b0;
    case (state_q)
      S_PARK: begin
        if (arm && start_en) begin
          mem_rd   = 1'b1;
          mem_addr = {{(AW-3){1'b0}}, frame_sel};
          state_d  = S_TBL;
        end
      end
      S_TBL: begin
        if (!arm || entry == '0) begin
          state_d = S_PARK;
        end else begin
          mem_rd   = 1'b1;
          mem_addr = entry;
          ptr_d    = AW'(entry + 1'b1);
          state_d  = S_HDR;
        end
      end
      S_HDR: begin
        if (!arm) begin
          state_d = S_PARK;
        end else begin
          hdr_we   = 1'b1;
          slot_clr = 1'b1;
          idx_d    = '0;
          if (hdr_in.len == '0) begin
            state_d = S_DONE;
          end else begin
            mem_rd  = 1'b1;
            ptr_d   = AW'(ptr_q + 1'b1);
            state_d = S_WRD;
          end
        end
      end
      S_WRD: begin
        if (!arm) begin
          state_d = S_PARK;
        end else begin
          slot_we = 1'b1;
          idx_d   = 4'(idx_q + 4'd1);
          if (idx_q == 4'(hdr_q.len - 4'd1)) begin
            state_d = S_DONE;
          end else begin
            mem_rd = 1'b1;
            ptr_d  = AW'(ptr_q + 1'b1);
          end
        end
      end
      S_DONE: begin
        if (!arm) begin
          state_d = S_PARK;
        end else if (p_take) begin
          if (hdr_q.last) begin
            state_d = S_PARK;
          end else begin
            mem_rd  = 1'b1;
            ptr_d   = AW'(ptr_q + 1'b1);
            state_d = S_HDR;
          end
        end
      end
      default: state_d = S_PARK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_PARK;
      ptr_q   <= '0;
      idx_q   <= '0;
      hdr_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      if (hdr_we) hdr_q <= hdr_in;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q[i] <= '0;
      else if (slot_clr)                         slot_q[i] <= '0;
      else if (slot_we && idx_q == 4'(i))        slot_q[i] <= mem_rdata;
    end
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_coef
    assign p_line.coef[k*WORD_W +: WORD_W] = slot_q[k+1];
  end
  assign p_line.hdr = hdr_q;
  assign p_line.dur = slot_q[0];
  assign p_valid    = (state_q == S_DONE);

  // R2: word capture never runs past the length field
  p_wrd_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WRD) |-> (idx_q < hdr_q.len));
endmodule

// File: rtl/line_hold.sv
module line_hold
  import frame_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  arm,
  input  logic  trig,
  input  logic  p_valid,
  input  line_t p_line,
  output logic  p_take,
  input  logic  ln_ready,
  output logic  ln_valid,
  output line_t ln_line,
  output logic  aux_o
);
  logic  full_q, full_d;
  logic  wait_q, wait_d;
  logic  aux_q, aux_d;
  line_t line_q;
  logic  trig_ok, fire;

  assign trig_ok  = trig || !(line_q.hdr.trig_req || wait_q);
  assign ln_valid = full_q && arm && trig_ok;
  assign fire     = ln_valid && ln_ready;
  assign p_take   = p_valid && arm && (!full_q || fire);

  always_comb begin
    full_d = full_q;
    wait_d = wait_q;
    aux_d  = aux_q;
    if (!arm) begin
      full_d = 1'b0;
      wait_d = 1'b0;
    end else begin
      if (p_take)    full_d = 1'b1;
      else if (fire) full_d = 1'b0;
      if (fire)      wait_d = line_q.hdr.wait_next;
    end
    if (fire) aux_d = line_q.hdr.aux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      wait_q <= 1'b0;
      aux_q  <= 1'b0;
      line_q <= '0;
    end else begin
      full_q <= full_d;
      wait_q <= wait_d;
      aux_q  <= aux_d;
      if (p_take) line_q <= p_line;
    end
  end

  assign ln_line = line_q;
  assign aux_o   = aux_q;

  // R5: a triggered line is offered only with the trigger level high
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_valid && ln_line.hdr.trig_req) |-> trig);
  // R6: a line after a wait line is offered only with the trigger level high
  p_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_valid && wait_q) |-> trig);
  // R7: nothing is offered while disarmed
  p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |-> !ln_valid);
  // R9: an offered but unaccepted line is kept unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_valid && !ln_ready) |=> $stable(ln_line));
  // R10: aux level follows the accepted line
  p_aux_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_valid && ln_ready) |=> (aux_o == $past(ln_line.hdr.aux)));
endmodule

// File: rtl/frame_line_seq.sv
module frame_line_seq
  import frame_seq_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              start_en,
  input  logic [2:0]        frame_sel,
  input  logic              ext_trig,
  input  logic              soft_trig,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ln_valid,
  input  logic              ln_ready,
  output logic [1:0]        ln_typ,
  output logic [1:0]        ln_shift,
  output logic              ln_trigger,
  output logic              ln_wait,
  output logic              ln_end,
  output logic              ln_clear,
  output logic              ln_silence,
  output logic              ln_aux,
  output logic [WORD_W-1:0] ln_dur,
  output logic [DATA_W-1:0] ln_data,
  output logic              aux_out
);
  logic  p_valid, p_take;
  line_t p_line, o_line;

  line_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .arm(arm), .start_en(start_en),
    .frame_sel(frame_sel), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .p_valid(p_valid), .p_line(p_line),
    .p_take(p_take)
  );

  line_hold u_hold (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig(ext_trig | soft_trig),
    .p_valid(p_valid), .p_line(p_line), .p_take(p_take),
    .ln_ready(ln_ready), .ln_valid(ln_valid), .ln_line(o_line),
    .aux_o(aux_out)
  );

  assign ln_typ     = o_line.hdr.typ;
  assign ln_shift   = o_line.hdr.shift;
  assign ln_trigger = o_line.hdr.trig_req;
  assign ln_wait    = o_line.hdr.wait_next;
  assign ln_end     = o_line.hdr.last;
  assign ln_clear   = o_line.hdr.clr;
  assign ln_silence = o_line.hdr.silence;
  assign ln_aux     = o_line.hdr.aux;
  assign ln_dur     = o_line.dur;
  assign ln_data    = o_line.coef;

  // R7: a held-low arm stops all memory traffic
  p_disarm_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && $past(!arm)) |-> !mem_rd);
  // R8: with starts disabled and no line in flight, memory stays idle
  p_nostart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_en && $past(!start_en) && $past(!arm)) |-> !mem_rd);
endmodule

// File: tb/sim_frame_line_seq.sv
module sim_frame_line_seq;
  localparam int AW = 10;
  localparam int MW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, arm, start_en, ext_trig, soft_trig, ln_ready;
  logic [2:0] frame_sel;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata;
  logic ln_valid, ln_trigger, ln_wait, ln_end, ln_clear, ln_silence, ln_aux, aux_out;
  logic [1:0] ln_typ, ln_shift;
  logic [15:0] ln_dur;
  logic [223:0] ln_data;

  logic [15:0] mem [MW];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int exp_ptr;
  int cur_sel;

  always #5 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  frame_line_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .start_en(start_en),
    .frame_sel(frame_sel), .ext_trig(ext_trig), .soft_trig(soft_trig),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ln_valid(ln_valid), .ln_ready(ln_ready), .ln_typ(ln_typ),
    .ln_shift(ln_shift), .ln_trigger(ln_trigger), .ln_wait(ln_wait),
    .ln_end(ln_end), .ln_clear(ln_clear), .ln_silence(ln_silence),
    .ln_aux(ln_aux), .ln_dur(ln_dur), .ln_data(ln_data), .aux_out(aux_out)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_flags(input logic [15:0] h);
    return {h[15], h[14], h[13], h[12:11], h[8], h[7], h[6], h[5:4]};
  endfunction

  function automatic logic [15:0] exp_dur(input int p);
    logic [15:0] h = mem[p % MW];
    return (h[3:0] >= 1) ? mem[(p + 1) % MW] : 16'h0;
  endfunction

  function automatic logic [223:0] exp_coef(input int p);
    logic [15:0] h = mem[p % MW];
    logic [223:0] d = '0;
    for (int k = 0; k < 14; k++)
      if (k + 2 <= int'(h[3:0])) d[k*16 +: 16] = mem[(p + 2 + k) % MW];
    return d;
  endfunction

  task automatic consume(input int n, input bit stall, input string tag);
    int got = 0;
    int guard = 0;
    bit chk = 0;
    logic xaux = 1'b0;
    logic [15:0] h;
    while (got < n && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (chk) begin
        check(aux_out == xaux, "R10 aux level", 256'(aux_out), 256'(xaux));
        chk = 0;
      end
      ln_ready = stall ? ($urandom % 3 == 0) : 1'b1;
      if (ln_valid && ln_ready) begin
        h = mem[exp_ptr % MW];
        check({ln_wait, ln_clear, ln_end, ln_shift, ln_aux, ln_silence, ln_trigger, ln_typ}
              == exp_flags(h), {tag, " header fields R2"},
              256'({ln_wait, ln_clear, ln_end, ln_shift, ln_aux, ln_silence, ln_trigger, ln_typ}),
              256'(exp_flags(h)));
        check(ln_dur == exp_dur(exp_ptr), {tag, " duration R2"}, 256'(ln_dur),
              256'(exp_dur(exp_ptr)));
        check(ln_data == exp_coef(exp_ptr), {tag, " coefficients R3"}, 256'(ln_data),
              256'(exp_coef(exp_ptr)));
        xaux = h[8];
        chk = 1;
        got++;
        if (h[13]) exp_ptr = int'(mem[cur_sel][AW-1:0]);
        else       exp_ptr = (exp_ptr + 1 + int'(h[3:0])) % MW;
      end
    end
    @(negedge clk);
    ln_ready = 1'b0;
    if (chk) check(aux_out == xaux, "R10 aux level", 256'(aux_out), 256'(xaux));
    check(got == n, {tag, " lines delivered R9"}, 256'(got), 256'(n));
  endtask

  task automatic restart(input int sel);
    @(negedge clk);
    arm = 1'b0;
    repeat (3) @(negedge clk);
    frame_sel = 3'(sel);
    cur_sel = sel;
    exp_ptr = int'(mem[sel][AW-1:0]);
    arm = 1'b1;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    int a;
    int nrand;
    bit seen;
    void'($urandom(32'h5eed));
    for (int i = 0; i < MW; i++) mem[i] = 16'h0;
    // frame jump table
    mem[0] = 16'd16; mem[1] = 16'd64; mem[2] = 16'd0; mem[3] = 16'd400;
    // frame 0: short, full-length and end line
    mem[16] = 16'h0001; mem[17] = 16'd7;
    mem[18] = 16'h111F; mem[19] = 16'd9;
    for (int k = 0; k < 14; k++) mem[20 + k] = 16'(16'hA000 + k);
    mem[34] = 16'h2084; mem[35] = 16'd3; mem[36] = 16'h1234; mem[37] = 16'h5678;
    mem[38] = 16'hBEEF;
    mem[39] = 16'hFFFF;
    // frame 1: random lines
    nrand = 12;
    a = 64;
    for (int i = 0; i < nrand; i++) begin
      logic [15:0] h = 16'($urandom);
      h[13] = (i == nrand - 1);
      h[3:0] = 4'(1 + ($urandom % 15));
      mem[a] = h;
      for (int k = 1; k <= int'(h[3:0]); k++) mem[a + k] = 16'($urandom);
      a = a + 1 + int'(h[3:0]);
    end
    // frame 3: triggered, wait, end
    mem[400] = 16'h0152; mem[401] = 16'd5; mem[402] = 16'h0ABC;
    mem[403] = 16'h8001; mem[404] = 16'd6;
    mem[405] = 16'h2003; mem[406] = 16'd2; mem[407] = 16'h1111; mem[408] = 16'h2222;

    rst_n = 1'b0; arm = 1'b0; start_en = 1'b0; frame_sel = 3'd0;
    ext_trig = 1'b0; soft_trig = 1'b0; ln_ready = 1'b0;
    cur_sel = 0; exp_ptr = 0;
    repeat (3) @(negedge clk);
    check(!ln_valid && !mem_rd && !aux_out, "R11 reset outputs",
          256'({ln_valid, mem_rd, aux_out}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(!ln_valid && !mem_rd && !aux_out, "R11 after reset",
          256'({ln_valid, mem_rd, aux_out}), 256'(0));

    // R8: starts disabled
    arm = 1'b1;
    seen = 0;
    repeat (20) begin @(negedge clk); if (mem_rd) seen = 1; end
    check(!seen, "R8 no read without start", 256'(seen), 256'(0));

    // R8: table entry zero parks
    frame_sel = 3'd2;
    start_en = 1'b1;
    seen = 0;
    repeat (40) begin @(negedge clk); if (ln_valid) seen = 1; end
    check(!seen, "R8 zero entry parks", 256'(seen), 256'(0));

    // R1 R4: frame 0, wrap back through the table
    ext_trig = 1'b1;
    restart(0);
    consume(4, 1'b0, "R1 R4 frame0");

    // R9: random frame with random ready stalls
    restart(1);
    consume(nrand + 3, 1'b1, "R9 random");

    // R7: disarm while a line is offered
    restart(1);
    consume(2, 1'b0, "R7 pre");
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin @(negedge clk); if (ln_valid) seen = 1; end
    arm = 1'b0;
    #1;
    check(!ln_valid, "R7 disarm drops offer", 256'(ln_valid), 256'(0));
    repeat (2) @(negedge clk);
    check(!mem_rd && !ln_valid, "R7 idle while disarmed",
          256'({mem_rd, ln_valid}), 256'(0));
    exp_ptr = int'(mem[1][AW-1:0]);
    arm = 1'b1;
    consume(2, 1'b0, "R7 restart at frame start");

    // R5 R6: trigger and wait gating
    ext_trig = 1'b0;
    restart(3);
    seen = 0;
    repeat (30) begin @(negedge clk); if (ln_valid) seen = 1; end
    check(!seen, "R5 triggered line held", 256'(seen), 256'(0));
    soft_trig = 1'b1;
    #1;
    check(ln_valid, "R5 soft trigger releases", 256'(ln_valid), 256'(1));
    consume(1, 1'b0, "R5 R10 line A");
    soft_trig = 1'b0;
    consume(1, 1'b0, "R5 untriggered line B");
    seen = 0;
    repeat (30) begin @(negedge clk); if (ln_valid) seen = 1; end
    check(!seen, "R6 wait holds next line", 256'(seen), 256'(0));
    ext_trig = 1'b1;
    #1;
    check(ln_valid, "R6 parsed ahead, offered at trigger", 256'(ln_valid), 256'(1));
    consume(1, 1'b0, "R6 line C");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule